// File: doc/BRIEF.md
# Serial Condition-Code Writer with Jump Match

This block gives a host microcontroller a serial port into a DSP core's program sequencer. The host pulls `rq_n` low and clocks two bytes in on `si`, each bit sampled on a rising `sclk`. The first byte is a command byte and the second is an 8-bit software condition code. The block does not update its condition register when the last bit arrives. It holds the byte and drops `rdy`. At the next leading edge of the audio frame clock `lrclk` it commits the byte and raises `rdy` again.

The sequencer presents the 11-bit condition-select field of the current instruction on `cond_sel`. A combinational output `jump_taken` goes high when any selected bit is also high in the condition vector. That vector holds the committed 8-bit code and three synchronised condition pins.

The block has two resets. The initialising reset clears everything, including the code. The core's soft reset leaves the code and the write port untouched and only flushes the pin synchronisers. Writes therefore work while the core is held in soft reset.

The state machine has four states:
- `ST_IDLE`: waiting for `rq_n` low.
- `ST_SHIFT`: collecting bits.
- `ST_DRAIN`: ignoring traffic until `rq_n` rises.
- `ST_HOLD`: byte captured, `rdy` low, waiting for the frame edge.

Its transitions are:
- IDLE→SHIFT on `rq_n` low.
- SHIFT→IDLE on early `rq_n` high (abort).
- SHIFT→DRAIN on a wrong command byte.
- SHIFT→HOLD on the 16th bit.
- HOLD→IDLE or HOLD→DRAIN on the leading frame edge, chosen by whether `rq_n` is already high.
- DRAIN→IDLE on `rq_n` high.

Top module: `cjw_writer`

## Requirements
- R1: While `init_rst_n` is low and after its release, the software code is 0, `rdy` is 1, and the pin synchronisers hold 0.
- R2: A write frame is sent with `rq_n` low. `si` is sampled on each rising `sclk`, MSB first. The 8-bit command byte must equal 0xC4, and the 8-bit code byte follows it.
- R3: `rdy` goes low in the clock cycle after the 16th bit is sampled. Until the commit, the jump test still uses the previous code.
- R4: The code is committed on the leading `lrclk` edge. With `i2s_mode`=0 this is the rising edge; with `i2s_mode`=1 it is the falling edge. The other edge does nothing. `rdy` is 1 one clock after the leading edge.
- R5: While `rdy` is low, all `sclk`, `si` and `rq_n` activity is ignored, and the byte already captured is the one that gets committed.
- R6: If the command byte is not 0xC4, the code byte is discarded, `rdy` stays 1, and the code is unchanged.
- R7: If `rq_n` rises before 16 bits have been sampled, the transfer is dropped and the code is unchanged.
- R8: While `sys_rst_n` is low, the code is kept, writes and commits still work, and the pin bits read as 0.
- R9: `jump_taken` is 1 exactly when some bit is 1 both in `cond_sel` and in the vector {code[7:0] at bits 10..3, `jx_pin[2]` at bit 2, `jx_pin[1]` at bit 1, `jx_pin[0]` at bit 0}.
- R10: A change on `jx_pin` first affects `jump_taken` after two rising `clk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all host and frame inputs are sampled by it |
| init_rst_n | input | 1 | Initialising reset, asynchronous, active low |
| sys_rst_n | input | 1 | Core soft reset, synchronous, active low |
| i2s_mode | input | 1 | 1 selects falling `lrclk` as the leading edge |
| sclk | input | 1 | Host serial bit clock |
| rq_n | input | 1 | Host write request, active low |
| si | input | 1 | Host serial data |
| lrclk | input | 1 | Audio frame clock |
| jx_pin | input | 3 | Asynchronous hardware condition pins |
| cond_sel | input | 11 | Condition-select field of the current instruction |
| rdy | output | 1 | Low while a captured code awaits its frame edge |
| jump_taken | output | 1 | Any-bit match between `cond_sel` and the condition vector |

## Verification
Any internal state error shows at the ports in one of two ways. A corrupted code register or a wrong bit order changes the jump result for particular select patterns. A misplaced commit or a state machine stuck in HOLD shows up on `rdy`, or as the old code still matching after the frame edge. The bench sweeps all 2048 select values after each event. A code error is therefore visible in the same cycle it exists, and a handshake error is caught one clock after the expected frame edge.

// File: rtl/cjw_pkg.sv
package cjw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DRAIN,
        ST_HOLD
    } wr_state_e;
endpackage

// File: rtl/cjw_frame_edge.sv
module cjw_frame_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic invert,
    input  logic lrclk,
    output logic lead
);
    logic lr_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lr_prev <= 1'b0;
        else        lr_prev <= lrclk;
    end

    always_comb begin
        if (invert) lead = lr_prev & ~lrclk;
        else        lead = ~lr_prev & lrclk;
    end
endmodule

// File: rtl/cjw_pin_sync.sv
module cjw_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES == 1) begin : g_single
            logic [W-1:0] stg;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           stg <= '0;
                else if (!soft_rst_n) stg <= '0;
                else                  stg <= d;
            end
            assign q = stg;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] stg;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           stg <= '0;
                else if (!soft_rst_n) stg <= '0;
                else                  stg <= {stg[STAGES-2:0], d};
            end
            assign q = stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cjw_match.sv
module cjw_match #(
    parameter int CODE_W = 8,
    parameter int PIN_W  = 3
) (
    input  logic [CODE_W-1:0]       code,
    input  logic [PIN_W-1:0]        pins,
    input  logic [CODE_W+PIN_W-1:0] sel,
    output logic                    hit
);
    logic [CODE_W+PIN_W-1:0] vec;

    always_comb begin
        vec = {code, pins};
        hit = |(vec & sel);
    end
endmodule

// File: rtl/cjw_writer.sv
module cjw_writer
    import cjw_pkg::*;
#(
    parameter int               CODE_W      = 8,
    parameter int               CMD_W       = 8,
    parameter int               PIN_W       = 3,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CMD_W-1:0] CMD_CODE    = 8'hC4
) (
    input  logic                    clk,
    input  logic                    init_rst_n,
    input  logic                    sys_rst_n,
    input  logic                    i2s_mode,
    input  logic                    sclk,
    input  logic                    rq_n,
    input  logic                    si,
    input  logic                    lrclk,
    input  logic [PIN_W-1:0]        jx_pin,
    input  logic [CODE_W+PIN_W-1:0] cond_sel,
    output logic                    rdy,
    output logic                    jump_taken
);
    localparam int TOTAL = CMD_W + CODE_W;
    localparam int SH_W  = (CMD_W > CODE_W) ? CMD_W : CODE_W;
    localparam int CNT_W = $clog2(TOTAL);

    wr_state_e          state, nxt;
    logic [SH_W-1:0]    shreg;
    logic [SH_W-1:0]    shifted;
    logic [CNT_W-1:0]   cnt;
    logic               sclk_prev;
    logic               sclk_rise;
    logic               frame_lead;
    logic [CODE_W-1:0]  cond_q;
    logic [PIN_W-1:0]   pin_q;

    cjw_frame_edge u_edge (
        .clk    (clk),
        .rst_n  (init_rst_n),
        .invert (i2s_mode),
        .lrclk  (lrclk),
        .lead   (frame_lead)
    );

    cjw_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (init_rst_n),
        .soft_rst_n (sys_rst_n),
        .d          (jx_pin),
        .q          (pin_q)
    );

    cjw_match #(.CODE_W(CODE_W), .PIN_W(PIN_W)) u_match (
        .code (cond_q),
        .pins (pin_q),
        .sel  (cond_sel),
        .hit  (jump_taken)
    );

    assign sclk_rise = sclk & ~sclk_prev;
    assign shifted   = {shreg[SH_W-2:0], si};

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!rq_n) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (rq_n) begin
                    nxt = ST_IDLE;
                end else if (sclk_rise) begin
                    if (cnt == CNT_W'(CMD_W - 1) && shifted[CMD_W-1:0] != CMD_CODE)
                        nxt = ST_DRAIN;
                    else if (cnt == CNT_W'(TOTAL - 1))
                        nxt = ST_HOLD;
                end
            end
            ST_DRAIN: if (rq_n) nxt = ST_IDLE;
            ST_HOLD:  if (frame_lead) nxt = rq_n ? ST_IDLE : ST_DRAIN;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge init_rst_n) begin
        if (!init_rst_n) state <= ST_IDLE;
        else             state <= nxt;
    end

    // shift path and commit
    always_ff @(posedge clk or negedge init_rst_n) begin
        if (!init_rst_n) begin
            sclk_prev <= 1'b0;
            shreg     <= '0;
            cnt       <= '0;
            cond_q    <= '0;
        end else begin
            sclk_prev <= sclk;
            if (state == ST_SHIFT) begin
                if (sclk_rise) begin
                    shreg <= shifted;
                    cnt   <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
            if (state == ST_HOLD && frame_lead)
                cond_q <= shreg[CODE_W-1:0];
        end
    end

    // outputs
    always_comb begin
        rdy = (state != ST_HOLD);
    end
endmodule

// File: rtl/cjw_writer_chk.sv
module cjw_writer_chk #(
    parameter int CODE_W = 8,
    parameter int PIN_W  = 3
) (
    input logic                    clk,
    input logic                    init_rst_n,
    input logic                    sys_rst_n,
    input logic                    rdy,
    input logic                    lead,
    input logic [CODE_W-1:0]       cond_q,
    input logic [PIN_W-1:0]        pin_q,
    input logic [CODE_W+PIN_W-1:0] cond_sel,
    input logic                    jump_taken
);
    AST_CODE_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!init_rst_n)
        !$stable(cond_q) |-> $past(!rdy && lead)); // R4

    AST_RDY_HELD_LOW: assert property (@(posedge clk) disable iff (!init_rst_n)
        (!rdy && !lead) |=> !rdy); // R5

    AST_RDY_RISES_AFTER_EDGE: assert property (@(posedge clk) disable iff (!init_rst_n)
        (!rdy && lead) |=> rdy); // R4

    AST_NO_SEL_NO_JUMP: assert property (@(posedge clk) disable iff (!init_rst_n)
        (cond_sel == '0) |-> !jump_taken); // R9

    AST_SOFT_RESET_KEEPS_CODE: assert property (@(posedge clk) disable iff (!init_rst_n)
        (!sys_rst_n && rdy) |=> $stable(cond_q)); // R8

    AST_SOFT_RESET_FLUSHES_PINS: assert property (@(posedge clk) disable iff (!init_rst_n)
        !sys_rst_n |=> (pin_q == '0)); // R8
endmodule

bind cjw_writer cjw_writer_chk #(.CODE_W(CODE_W), .PIN_W(PIN_W)) u_chk (
    .clk        (clk),
    .init_rst_n (init_rst_n),
    .sys_rst_n  (sys_rst_n),
    .rdy        (rdy),
    .lead       (frame_lead),
    .cond_q     (cond_q),
    .pin_q      (pin_q),
    .cond_sel   (cond_sel),
    .jump_taken (jump_taken)
);

// File: tb/sim_cjw_writer.sv
module sim_cjw_writer;
    logic        clk = 1'b0;
    logic        init_rst_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        i2s_mode = 1'b0;
    logic        sclk = 1'b0;
    logic        rq_n = 1'b1;
    logic        si = 1'b0;
    logic        lrclk = 1'b0;
    logic [2:0]  jx_pin = 3'b000;
    logic [10:0] cond_sel = '0;
    logic        rdy;
    logic        jump_taken;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    logic [7:0] code_m = 8'h00;
    logic [2:0] jx_m = 3'b000;

    always #4 clk = ~clk;

    cjw_writer u0 (
        .clk(clk), .init_rst_n(init_rst_n), .sys_rst_n(sys_rst_n),
        .i2s_mode(i2s_mode), .sclk(sclk), .rq_n(rq_n), .si(si),
        .lrclk(lrclk), .jx_pin(jx_pin), .cond_sel(cond_sel),
        .rdy(rdy), .jump_taken(jump_taken)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 2048; s++) begin
            logic exp;
            cond_sel = 11'(s);
            #1;
            exp = |({code_m, jx_m} & 11'(s));
            n_checks++;
            if (jump_taken !== exp) begin
                n_errors++;
                $display("FAIL %s: sel=%h actual=%b expected=%b", req, s, jump_taken, exp);
            end
        end
        cond_sel = '0;
        tick(1);
    endtask

    task automatic send(input logic [15:0] w, input int nbits);
        rq_n = 1'b0;
        tick(2);
        for (int i = 0; i < nbits; i++) begin
            si   = w[15-i];
            sclk = 1'b0;
            tick(2);
            sclk = 1'b1;
            tick(2);
        end
        sclk = 1'b0;
        tick(1);
        rq_n = 1'b1;
        tick(2);
    endtask

    task automatic finish_up;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_up();
    end

    initial begin
        tick(3);
        check_bit("R1 rdy in reset", rdy, 1'b1);
        init_rst_n = 1'b1;
        tick(2);
        check_bit("R1 rdy after reset", rdy, 1'b1);
        sweep("R1 cleared code");

        // R2 R3: good write, deferred commit
        send({8'hC4, 8'hA5}, 16);
        check_bit("R3 rdy low after 16 bits", rdy, 1'b0);
        sweep("R3 old code before commit");

        // R5: traffic while rdy low is ignored
        send({8'hC4, 8'h3C}, 16);
        check_bit("R5 rdy still low", rdy, 1'b0);

        // R4: rising edge commits in normal mode
        lrclk = 1'b1;
        tick(1);
        check_bit("R4 rdy high after edge", rdy, 1'b1);
        code_m = 8'hA5;
        sweep("R2 R4 R5 committed code");
        lrclk = 1'b0;
        tick(2);

        // R6: wrong command
        send({8'h55, 8'h0F}, 16);
        check_bit("R6 rdy stays high", rdy, 1'b1);
        lrclk = 1'b1; tick(2); lrclk = 1'b0; tick(2);
        sweep("R6 code unchanged");

        // R7: aborted write
        send({8'hC4, 8'hFF}, 10);
        check_bit("R7 rdy high after abort", rdy, 1'b1);
        lrclk = 1'b1; tick(2); lrclk = 1'b0; tick(2);
        sweep("R7 code unchanged");

        // R4: inverted frame polarity
        i2s_mode = 1'b1;
        tick(1);
        send({8'hC4, 8'h5A}, 16);
        check_bit("R3 rdy low i2s", rdy, 1'b0);
        lrclk = 1'b1;
        tick(2);
        check_bit("R4 rising ignored in i2s", rdy, 1'b0);
        lrclk = 1'b0;
        tick(1);
        check_bit("R4 falling commits in i2s", rdy, 1'b1);
        code_m = 8'h5A;
        sweep("R4 i2s committed code");
        i2s_mode = 1'b0;
        tick(1);

        // R10: two-stage pin latency
        cond_sel = 11'b001;
        jx_pin   = 3'b001;
        tick(1);
        check_bit("R10 one edge no effect", jump_taken, 1'b0);
        tick(1);
        check_bit("R10 two edges visible", jump_taken, 1'b1);
        cond_sel = '0;

        // R9: all pin combinations
        for (int j = 0; j < 8; j++) begin
            jx_pin = 3'(j);
            tick(3);
            jx_m = 3'(j);
            sweep("R9 match");
        end

        // R8: soft reset
        jx_pin = 3'b111;
        sys_rst_n = 1'b0;
        tick(2);
        jx_m = 3'b000;
        sweep("R8 pins flushed code kept");
        send({8'hC4, 8'hC3}, 16);
        check_bit("R8 write in soft reset", rdy, 1'b0);
        lrclk = 1'b1;
        tick(1);
        check_bit("R8 commit in soft reset", rdy, 1'b1);
        lrclk = 1'b0;
        code_m = 8'hC3;
        tick(1);
        sweep("R8 code written in soft reset");
        sys_rst_n = 1'b1;
        tick(3);
        jx_m = 3'b111;
        sweep("R8 pins back");

        // R1: initialising reset clears code
        init_rst_n = 1'b0;
        tick(2);
        check_bit("R1 rdy in second reset", rdy, 1'b1);
        init_rst_n = 1'b1;
        tick(3);
        code_m = 8'h00;
        sweep("R1 code cleared again");

        finish_up();
    end
endmodule